// File: doc/BRIEF.md
# I2C Register Table Loader

This block programs a video decoder over a two-wire I2C bus straight after reset, with no processor in the loop. A constant table on chip holds pairs of (register sub-address, value). A sequencer walks that table from the first entry to the last. For each entry it runs one complete write transaction: a start condition, the device address with the write bit, the sub-address, the value, and a stop condition. Underneath it, a bit engine drives the clock and data lines in open-drain style. Each line is pulled low by asserting its output enable, and the data line is read back on a separate input.

The engine checks for an acknowledge after every byte. If a byte is refused, the current transaction is cut short with a stop condition. The same entry is then sent again, up to a set number of retries. When the table has been written, the block raises `done`. When the retries for any entry run out, it raises `error` instead. In either case it leaves both lines released and keeps the outcome flag set until the next reset. A quarter-bit tick derived from the system clock sets the bus timing. It is sized so that each clock phase lasts at least a chosen number of system clocks. The default of 500 clocks gives 100 kHz from a 100 MHz system clock.

Top module: `i2c_reg_loader`

## Requirements
- R1: While and right after `rst` is high, `scl_oe` and `sda_oe` are 0 (both lines released), and `done` and `error` are 0.
- R2: Each table entry goes out as one transaction, in this order: start, the byte `{DEV_ADDR,0}`, the sub-address byte, the value byte, stop. Every byte is sent most significant bit first. Entries go out in index order 0 to NUM_ENTRIES-1. Entries 0 to 2 of the default table are (0x02,0xC0), (0x03,0x33) and (0x04,0x00).
- R3: During a byte, SDA changes only while SCL is low. A start condition is SDA falling while SCL is high. A stop condition is SDA rising while SCL is high. The number of starts equals the number of stops.
- R4: Every high phase and every low phase of SCL lasts at least PHASE_CLKS system clocks.
- R5: On the ninth clock of each byte, the block releases SDA (`sda_oe`=0) while SCL is high. SDA sampled low in that phase counts as an acknowledge; sampled high counts as a refusal.
- R6: After a refused byte, no further byte of that transaction is sent, and a stop condition follows.
- R7: After a refusal the same entry is sent again, up to MAX_RETRY repeats. The repeat count starts from zero again for each new entry.
- R8: If an entry is still refused after MAX_RETRY repeats, `error` goes to 1 and stays there. `done` stays 0, both lines are released, and no further bus activity occurs.
- R9: After the stop condition of the last entry, `done` goes to 1 and stays there. Both lines are released, and no further transaction starts.
- R10: `done` and `error` are never 1 at the same time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; the table walk starts when it is released |
| sda_in | input | 1 | Level sensed on the data line |
| scl_oe | output | 1 | 1 pulls the clock line low, 0 releases it |
| sda_oe | output | 1 | 1 pulls the data line low, 0 releases it |
| done | output | 1 | Whole table written and acknowledged |
| error | output | 1 | An entry was refused more often than the retry limit allows |

## Verification
The bench builds the block with PHASE_CLKS=4, NUM_ENTRIES=3 and MAX_RETRY=2. With these values a whole table walk, including several retries, takes a few thousand clocks. The short phase keeps the start, stop and acknowledge edges close together, which exposes any off-by-one in the quarter sequencing. A retry limit of two makes it possible to show both cases. A run where two refusals of one entry followed by a refusal of the next must still succeed only works if the count restarts per entry. A run of constant refusals reaches the abort after exactly three attempts.

// File: rtl/i2c_init_pkg.sv
package i2c_init_pkg;

  typedef enum logic [1:0] {
    CMD_START = 2'd0,
    CMD_BYTE  = 2'd1,
    CMD_STOP  = 2'd2
  } i2c_cmd_e;

  typedef struct packed {
    logic [7:0] sub;
    logic [7:0] val;
  } cfg_entry_t;

  // Decoder setup list; indices past the listed ones map to zeroed registers.
  function automatic cfg_entry_t cfg_lookup(input int unsigned idx);
    cfg_entry_t e;
    case (idx)
      0: e = '{sub: 8'h02, val: 8'hC0};
      1: e = '{sub: 8'h03, val: 8'h33};
      2: e = '{sub: 8'h04, val: 8'h00};
      3: e = '{sub: 8'h05, val: 8'h00};
      4: e = '{sub: 8'h06, val: 8'hE9};
      5: e = '{sub: 8'h07, val: 8'h0D};
      6: e = '{sub: 8'h08, val: 8'h98};
      7: e = '{sub: 8'h09, val: 8'h01};
      default: begin
        e.sub = 8'(idx + 2);
        e.val = 8'h00;
      end
    endcase
    return e;
  endfunction

endpackage

// File: rtl/i2c_qtick.sv
module i2c_qtick #(
  parameter int QTR_CLKS = 250
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  output logic tick
);
  localparam int CW = $clog2(QTR_CLKS + 1);

  logic [CW-1:0] cnt;

  assign tick = !clr && (cnt == CW'(QTR_CLKS - 1));

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else if (tick) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/i2c_cfg_rom.sv
module i2c_cfg_rom
  import i2c_init_pkg::*;
#(
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic [AW-1:0] addr,
  output cfg_entry_t    rd
);
  // Registered read of a constant function: maps onto a block ROM.
  always_ff @(posedge clk) begin
    rd <= cfg_lookup(int'(addr));
  end
endmodule

// File: rtl/i2c_bit_engine.sv
module i2c_bit_engine
  import i2c_init_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       qtick,
  input  logic       cmd_valid,
  input  i2c_cmd_e   cmd_kind,
  input  logic [7:0] cmd_byte,
  output logic       cmd_ready,
  output logic       rsp_valid,
  output logic       rsp_nack,
  input  logic       sda_in,
  output logic       scl_oe,
  output logic       sda_oe,
  output logic       edge_cmd_active
);
  logic       busy;
  i2c_cmd_e   kind;
  logic [1:0] qtr;
  logic [3:0] bitn;
  logic [7:0] shreg;
  logic [1:0] sda_sync;
  logic       accept;

  assign cmd_ready       = !busy;
  assign accept          = cmd_valid && !busy;
  assign edge_cmd_active = busy && (kind != CMD_BYTE);

  always_ff @(posedge clk) begin
    if (rst) begin
      sda_sync <= 2'b11;
    end else begin
      sda_sync <= {sda_sync[0], sda_in};
    end
  end

  // Each command is four quarters per bit; outputs change on quarter entry.
  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      kind      <= CMD_START;
      qtr       <= 2'd0;
      bitn      <= 4'd0;
      shreg     <= 8'h00;
      scl_oe    <= 1'b0;
      sda_oe    <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_nack  <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      if (accept) begin
        busy     <= 1'b1;
        kind     <= cmd_kind;
        qtr      <= 2'd0;
        bitn     <= 4'd0;
        shreg    <= cmd_byte;
        rsp_nack <= 1'b0;
        if (cmd_kind == CMD_START) begin
          scl_oe <= 1'b0;
          sda_oe <= 1'b0;
        end else begin
          scl_oe <= 1'b1;
        end
      end else if (busy && qtick) begin
        qtr <= qtr + 2'd1;
        case (kind)
          CMD_START: begin
            case (qtr)
              2'd0: sda_oe <= 1'b1;
              2'd2: scl_oe <= 1'b1;
              2'd3: begin
                busy      <= 1'b0;
                rsp_valid <= 1'b1;
              end
              default: ;
            endcase
          end
          CMD_BYTE: begin
            case (qtr)
              2'd0: sda_oe <= (bitn < 4'd8) ? ~shreg[7] : 1'b0;
              2'd1: scl_oe <= 1'b0;
              2'd2: if (bitn == 4'd8) rsp_nack <= sda_sync[1];
              default: begin
                if (bitn == 4'd8) begin
                  busy      <= 1'b0;
                  rsp_valid <= 1'b1;
                end else begin
                  bitn   <= bitn + 4'd1;
                  shreg  <= {shreg[6:0], 1'b0};
                  scl_oe <= 1'b1;
                end
              end
            endcase
          end
          default: begin
            case (qtr)
              2'd0: sda_oe <= 1'b1;
              2'd1: scl_oe <= 1'b0;
              2'd2: sda_oe <= 1'b0;
              default: begin
                busy      <= 1'b0;
                rsp_valid <= 1'b1;
              end
            endcase
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_cmd_seq.sv
module i2c_cmd_seq
  import i2c_init_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h25,
  parameter int         NUM_ENTRIES = 8,
  parameter int         MAX_RETRY   = 3,
  parameter int         IDX_W       = 3,
  parameter int         RTRY_W      = 3
) (
  input  logic             clk,
  input  logic             rst,
  output logic [IDX_W-1:0] rom_addr,
  input  cfg_entry_t       rom_rd,
  output logic             cmd_valid,
  output i2c_cmd_e         cmd_kind,
  output logic [7:0]       cmd_byte,
  input  logic             cmd_ready,
  input  logic             rsp_valid,
  input  logic             rsp_nack,
  output logic             done,
  output logic             error
);
  typedef enum logic [2:0] {SQ_FETCH, SQ_ISSUE, SQ_WAIT, SQ_FINISH, SQ_FAIL} sq_e;
  typedef enum logic [2:0] {ST_START, ST_DEV, ST_SUB, ST_DAT, ST_STOP} st_e;

  sq_e              state;
  st_e              step;
  logic [IDX_W-1:0] idx;
  logic [RTRY_W-1:0] retry;
  logic             nacked;

  assign rom_addr  = idx;
  assign cmd_valid = (state == SQ_ISSUE);

  always_comb begin
    cmd_kind = CMD_BYTE;
    cmd_byte = 8'h00;
    case (step)
      ST_START: cmd_kind = CMD_START;
      ST_DEV:   cmd_byte = {DEV_ADDR, 1'b0};
      ST_SUB:   cmd_byte = rom_rd.sub;
      ST_DAT:   cmd_byte = rom_rd.val;
      default:  cmd_kind = CMD_STOP;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= SQ_FETCH;
      step   <= ST_START;
      idx    <= '0;
      retry  <= '0;
      nacked <= 1'b0;
      done   <= 1'b0;
      error  <= 1'b0;
    end else begin
      case (state)
        SQ_FETCH: state <= SQ_ISSUE;
        SQ_ISSUE: if (cmd_ready) state <= SQ_WAIT;
        SQ_WAIT: begin
          if (rsp_valid) begin
            state <= SQ_ISSUE;
            case (step)
              ST_START: step <= ST_DEV;
              ST_DEV: begin
                nacked <= rsp_nack;
                step   <= rsp_nack ? ST_STOP : ST_SUB;
              end
              ST_SUB: begin
                nacked <= rsp_nack;
                step   <= rsp_nack ? ST_STOP : ST_DAT;
              end
              ST_DAT: begin
                nacked <= rsp_nack;
                step   <= ST_STOP;
              end
              default: begin
                step   <= ST_START;
                nacked <= 1'b0;
                if (nacked) begin
                  if (retry == RTRY_W'(MAX_RETRY)) begin
                    state <= SQ_FAIL;
                    error <= 1'b1;
                  end else begin
                    retry <= retry + 1'b1;
                  end
                end else if (idx == IDX_W'(NUM_ENTRIES - 1)) begin
                  state <= SQ_FINISH;
                  done  <= 1'b1;
                end else begin
                  idx   <= idx + 1'b1;
                  retry <= '0;
                  state <= SQ_FETCH;
                end
              end
            endcase
          end
        end
        default: state <= state;
      endcase
    end
  end
endmodule

// File: rtl/i2c_reg_loader.sv
module i2c_reg_loader
  import i2c_init_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h25,
  parameter int         NUM_ENTRIES = 8,
  parameter int         PHASE_CLKS  = 500,
  parameter int         MAX_RETRY   = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic sda_in,
  output logic scl_oe,
  output logic sda_oe,
  output logic done,
  output logic error
);
  localparam int QTR_CLKS = (PHASE_CLKS + 1) / 2;
  localparam int IDX_W    = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1;
  localparam int RTRY_W   = $clog2(MAX_RETRY + 2);

  logic             qtick;
  logic             cmd_valid;
  logic             cmd_ready;
  i2c_cmd_e         cmd_kind;
  logic [7:0]       cmd_byte;
  logic             rsp_valid;
  logic             rsp_nack;
  logic [IDX_W-1:0] rom_addr;
  cfg_entry_t       rom_rd;
  logic             edge_cmd_active;
  logic             tick_clr;

  assign tick_clr = cmd_valid && cmd_ready;

  i2c_qtick #(.QTR_CLKS(QTR_CLKS)) u_tick (
    .clk (clk),
    .rst (rst),
    .clr (tick_clr),
    .tick(qtick)
  );

  i2c_cfg_rom #(.AW(IDX_W)) u_rom (
    .clk (clk),
    .addr(rom_addr),
    .rd  (rom_rd)
  );

  i2c_cmd_seq #(
    .DEV_ADDR   (DEV_ADDR),
    .NUM_ENTRIES(NUM_ENTRIES),
    .MAX_RETRY  (MAX_RETRY),
    .IDX_W      (IDX_W),
    .RTRY_W     (RTRY_W)
  ) u_seq (
    .clk      (clk),
    .rst      (rst),
    .rom_addr (rom_addr),
    .rom_rd   (rom_rd),
    .cmd_valid(cmd_valid),
    .cmd_kind (cmd_kind),
    .cmd_byte (cmd_byte),
    .cmd_ready(cmd_ready),
    .rsp_valid(rsp_valid),
    .rsp_nack (rsp_nack),
    .done     (done),
    .error    (error)
  );

  i2c_bit_engine u_eng (
    .clk            (clk),
    .rst            (rst),
    .qtick          (qtick),
    .cmd_valid      (cmd_valid),
    .cmd_kind       (cmd_kind),
    .cmd_byte       (cmd_byte),
    .cmd_ready      (cmd_ready),
    .rsp_valid      (rsp_valid),
    .rsp_nack       (rsp_nack),
    .sda_in         (sda_in),
    .scl_oe         (scl_oe),
    .sda_oe         (sda_oe),
    .edge_cmd_active(edge_cmd_active)
  );
endmodule

// File: rtl/i2c_reg_loader_chk.sv
module i2c_reg_loader_chk #(
  parameter int PHASE_CLKS = 500
) (
  input logic clk,
  input logic rst,
  input logic scl_oe,
  input logic sda_oe,
  input logic done,
  input logic error,
  input logic edge_cmd_active
);
  localparam int RW = $clog2(PHASE_CLKS + 2);

  logic [RW-1:0] run;
  logic          scl_prev;

  // Length of the current SCL level, saturating at PHASE_CLKS.
  always_ff @(posedge clk) begin
    if (rst) begin
      run      <= '0;
      scl_prev <= 1'b0;
    end else begin
      scl_prev <= scl_oe;
      if (scl_oe != scl_prev) begin
        run <= RW'(1);
      end else if (run < RW'(PHASE_CLKS)) begin
        run <= run + 1'b1;
      end
    end
  end

  assert_scl_phase_R4: assert property (@(posedge clk) disable iff (rst)
    (scl_oe != scl_prev) |-> (run >= RW'(PHASE_CLKS)));

  assert_sda_stable_R3: assert property (@(posedge clk) disable iff (rst)
    (!scl_oe && !$past(scl_oe) && !edge_cmd_active && !$past(edge_cmd_active))
      |-> (sda_oe == $past(sda_oe)));

  assert_done_hold_R9: assert property (@(posedge clk) disable iff (rst)
    done |=> done);

  assert_done_release_R9: assert property (@(posedge clk) disable iff (rst)
    done |-> (!scl_oe && !sda_oe));

  assert_error_hold_R8: assert property (@(posedge clk) disable iff (rst)
    error |=> error);

  assert_error_release_R8: assert property (@(posedge clk) disable iff (rst)
    error |-> (!scl_oe && !sda_oe && !done));

  assert_flags_excl_R10: assert property (@(posedge clk) disable iff (rst)
    !(done && error));
endmodule

bind i2c_reg_loader i2c_reg_loader_chk #(.PHASE_CLKS(PHASE_CLKS)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .scl_oe         (scl_oe),
  .sda_oe         (sda_oe),
  .done           (done),
  .error          (error),
  .edge_cmd_active(edge_cmd_active)
);

// File: tb/test_i2c_reg_loader.sv
module test_i2c_reg_loader;
  localparam int TB_PHASE   = 4;
  localparam int TB_ENTRIES = 3;
  localparam int TB_RETRY   = 2;
  localparam logic [7:0] ADDR_W = 8'h4A;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sda_in;
  logic scl_oe, sda_oe, done, error;
  logic drv = 1'b0;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  assign sda_in = ~(sda_oe | drv);

  i2c_reg_loader #(
    .DEV_ADDR   (7'h25),
    .NUM_ENTRIES(TB_ENTRIES),
    .PHASE_CLKS (TB_PHASE),
    .MAX_RETRY  (TB_RETRY)
  ) i_i2c_reg_loader (
    .clk   (clk),
    .rst   (rst),
    .sda_in(sda_in),
    .scl_oe(scl_oe),
    .sda_oe(sda_oe),
    .done  (done),
    .error (error)
  );

  // Slave model and bus monitor, evaluated away from the active edge.
  logic [7:0] log_b [0:15][0:2];
  int   log_n [0:15];
  int   txn_cnt, start_cnt, stop_cnt, ack_conflict;
  int   min_low, min_high, run_len;
  bit   seen_edge;
  int   in_txn, bitcnt, ackph, bytecnt;
  logic [7:0] shin;
  logic prev_scl, prev_sda;
  int   nack_addr, nack_sub1;
  int   nack_dat [0:255];

  always @(negedge clk) begin
    logic scl_l, sda_l;
    scl_l = ~scl_oe;
    sda_l = sda_in;
    if (rst) begin
      txn_cnt = 0; start_cnt = 0; stop_cnt = 0; ack_conflict = 0;
      min_low = 1000000; min_high = 1000000; run_len = 0; seen_edge = 0;
      in_txn = 0; bitcnt = 0; ackph = 0; bytecnt = 0; shin = 8'h00;
      drv = 1'b0;
      for (int i = 0; i < 16; i++) begin
        log_n[i] = 0;
        for (int j = 0; j < 3; j++) log_b[i][j] = 8'h00;
      end
    end else begin
      if (scl_l != prev_scl) begin
        if (seen_edge) begin
          if (prev_scl) begin
            if (run_len < min_high) min_high = run_len;
          end else begin
            if (run_len < min_low) min_low = run_len;
          end
        end
        seen_edge = 1;
        run_len = 1;
      end else begin
        run_len++;
      end
      if (prev_scl && scl_l && prev_sda && !sda_l) begin
        in_txn = 1; bitcnt = 0; bytecnt = 0; ackph = 0; start_cnt++;
      end else if (prev_scl && scl_l && !prev_sda && sda_l) begin
        if (in_txn != 0 && txn_cnt < 16) log_n[txn_cnt] = bytecnt;
        if (in_txn != 0) txn_cnt++;
        in_txn = 0; stop_cnt++;
      end else if (!prev_scl && scl_l) begin
        if (in_txn != 0) begin
          if (ackph != 0) begin
            if (sda_oe) ack_conflict++;
          end else if (bitcnt < 8) begin
            shin = {shin[6:0], sda_l};
            bitcnt++;
          end
        end
      end else if (prev_scl && !scl_l) begin
        if (in_txn != 0) begin
          if (ackph != 0) begin
            ackph = 0; drv = 1'b0; bitcnt = 0; bytecnt++;
          end else if (bitcnt == 8) begin
            bit refuse;
            refuse = 0;
            ackph = 1;
            if (txn_cnt < 16 && bytecnt < 3) log_b[txn_cnt][bytecnt] = shin;
            if (bytecnt == 0 && nack_addr > 0) begin
              refuse = 1; nack_addr--;
            end else if (bytecnt == 1 && nack_sub1 > 0) begin
              refuse = 1; nack_sub1--;
            end else if (bytecnt == 2 && txn_cnt < 16 && nack_dat[log_b[txn_cnt][1]] > 0) begin
              refuse = 1; nack_dat[log_b[txn_cnt][1]]--;
            end
            drv = ~refuse;
          end
        end
      end
    end
    prev_scl = scl_l;
    prev_sda = sda_in;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("[TB] FAIL %s: %s got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic clear_policy();
    nack_addr = 0;
    nack_sub1 = 0;
    for (int i = 0; i < 256; i++) nack_dat[i] = 0;
  endtask

  task automatic hold_reset();
    rst = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic release_reset();
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wait_end(input string req);
    int k;
    k = 0;
    while (!(done || error) && k < 30000) begin
      @(negedge clk);
      k++;
    end
    chk(k < 30000, req, "cycles until finish", k, 30000);
    repeat (4) @(negedge clk);
  endtask

  task automatic expect_txn(input int t, input int n, input logic [7:0] b0,
                            input logic [7:0] b1, input logic [7:0] b2, input string req);
    logic [7:0] e [0:2];
    e[0] = b0; e[1] = b1; e[2] = b2;
    chk(log_n[t] == n, req, $sformatf("txn %0d byte count", t), log_n[t], n);
    for (int j = 0; j < n; j++)
      chk(log_b[t][j] == e[j], req, $sformatf("txn %0d byte %0d", t, j),
          int'(log_b[t][j]), int'(e[j]));
  endtask

  task automatic check_idle_after(input string req, input int txns, input bit exp_done,
                                  input bit exp_err);
    repeat (300) @(negedge clk);
    chk(txn_cnt == txns, req, "transactions after idle wait", txn_cnt, txns);
    chk(!scl_oe && !sda_oe, req, "lines released", {scl_oe, sda_oe}, 0);
    chk(done == exp_done, req, "done held", done, exp_done);
    chk(error == exp_err, req, "error held", error, exp_err);
  endtask

  task automatic t_reset_state();
    clear_policy();
    hold_reset();
    chk(scl_oe == 1'b0, "R1", "scl_oe in reset", scl_oe, 0);
    chk(sda_oe == 1'b0, "R1", "sda_oe in reset", sda_oe, 0);
    chk(done == 1'b0 && error == 1'b0, "R1", "flags in reset", {done, error}, 0);
    release_reset();
    @(negedge clk);
    chk(!scl_oe && !sda_oe && !done && !error, "R1", "state after release",
        {scl_oe, sda_oe, done, error}, 0);
  endtask

  task automatic t_clean_run();
    clear_policy();
    hold_reset();
    release_reset();
    wait_end("R9");
    chk(done == 1'b1, "R9", "done", done, 1);
    chk(error == 1'b0, "R10", "error with done", error, 0);
    chk(txn_cnt == 3, "R2", "transaction count", txn_cnt, 3);
    expect_txn(0, 3, ADDR_W, 8'h02, 8'hC0, "R2");
    expect_txn(1, 3, ADDR_W, 8'h03, 8'h33, "R2");
    expect_txn(2, 3, ADDR_W, 8'h04, 8'h00, "R2");
    chk(start_cnt == 3 && stop_cnt == 3, "R3", "start/stop count", start_cnt * 10 + stop_cnt, 33);
    chk(ack_conflict == 0, "R5", "SDA driven during ack", ack_conflict, 0);
    chk(min_low >= TB_PHASE, "R4", "shortest SCL low", min_low, TB_PHASE);
    chk(min_high >= TB_PHASE, "R4", "shortest SCL high", min_high, TB_PHASE);
    check_idle_after("R9", 3, 1'b1, 1'b0);
  endtask

  task automatic t_retry_recover();
    clear_policy();
    hold_reset();
    nack_dat[8'h03] = 2;
    nack_dat[8'h04] = 1;
    release_reset();
    wait_end("R7");
    chk(done == 1'b1 && error == 1'b0, "R7", "done after retries", {done, error}, 2);
    chk(txn_cnt == 6, "R7", "transaction count", txn_cnt, 6);
    expect_txn(0, 3, ADDR_W, 8'h02, 8'hC0, "R7");
    expect_txn(1, 3, ADDR_W, 8'h03, 8'h33, "R7");
    expect_txn(2, 3, ADDR_W, 8'h03, 8'h33, "R7");
    expect_txn(3, 3, ADDR_W, 8'h03, 8'h33, "R7");
    expect_txn(4, 3, ADDR_W, 8'h04, 8'h00, "R7");
    expect_txn(5, 3, ADDR_W, 8'h04, 8'h00, "R7");
    chk(start_cnt == stop_cnt, "R3", "start/stop balance", start_cnt, stop_cnt);
  endtask

  task automatic t_sub_refused();
    clear_policy();
    hold_reset();
    nack_sub1 = 1;
    release_reset();
    wait_end("R6");
    chk(txn_cnt == 4, "R6", "transaction count", txn_cnt, 4);
    expect_txn(0, 2, ADDR_W, 8'h02, 8'h00, "R6");
    expect_txn(1, 3, ADDR_W, 8'h02, 8'hC0, "R6");
    expect_txn(2, 3, ADDR_W, 8'h03, 8'h33, "R6");
    chk(done == 1'b1, "R6", "done after single refusal", done, 1);
  endtask

  task automatic t_abort();
    clear_policy();
    hold_reset();
    nack_addr = 100;
    release_reset();
    wait_end("R8");
    chk(error == 1'b1, "R8", "error", error, 1);
    chk(done == 1'b0, "R10", "done with error", done, 0);
    chk(txn_cnt == TB_RETRY + 1, "R8", "attempts", txn_cnt, TB_RETRY + 1);
    for (int t = 0; t < TB_RETRY + 1; t++)
      expect_txn(t, 1, ADDR_W, 8'h00, 8'h00, "R6");
    chk(start_cnt == stop_cnt, "R3", "start/stop balance", start_cnt, stop_cnt);
    check_idle_after("R8", TB_RETRY + 1, 1'b0, 1'b1);
  endtask

  initial begin
    clear_policy();
    t_reset_state();
    t_clean_run();
    t_retry_recover();
    t_sub_refused();
    t_abort();
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("[TB] FAIL watchdog: run did not end, got 0 expected 1");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule